// File: doc/BRIEF.md
# Latched-Address One-of-Eight Decoder

This block turns a three-bit binary address into eight active-low select lines. Exactly one line is pulled low for the chosen address and the rest stay high. A small address register sits in front of the decoder. While the hold input is low, the register is transparent: the decoder sees the live address and the outputs follow it in the same cycle. When hold is raised, the address that the register took in at the last clock edge with hold low is kept. Address changes have no effect until hold drops again. The outputs therefore stay clean while an address bus settles or is reused for other traffic.

Two gating inputs of opposite polarity, one active-high and one active-low, must both be asserted before any output can go low. When the gate is closed, all eight outputs sit high whatever the address, hold or stored value. Everything is synchronous to one system clock. A synchronous active-low reset clears only the stored address. The outputs are not forced by reset.

Top module: `latched_decoder`

## Requirements
- R1: Address bit 2 is the most significant and bit 0 the least significant. With the gate open and hold low, output bit `y_n_o[k]` is the one driven low when the address equals k.
- R2: With the gate open, exactly one output bit is low and the other seven are high.
- R3: While hold is low, the outputs follow the live address combinationally, with no clock cycle of delay.
- R4: When hold goes high, the decoder uses the address sampled at the last rising clock edge at which hold was low.
- R5: While hold stays high, changes on the address input do not alter the outputs.
- R6: All eight outputs are high unless `en_i` is 1 and `en_n_i` is 0. This holds for every address, hold value and stored value.
- R7: A rising clock edge with `rst_n` low clears the stored address to 0. Reset does not force the outputs; they still follow the gate and the address path.
- R8: After hold returns low, the outputs again follow the live address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the stored address |
| addr_i | input | 3 | Binary address; bit 2 most significant |
| hold_i | input | 1 | 0: address passes through; 1: stored address is used |
| en_i | input | 1 | Active-high output gate |
| en_n_i | input | 1 | Active-low output gate |
| y_n_o | output | 8 | Active-low select lines; bit k belongs to address k |

## Verification
The assertions check the following on every clock edge:
- the closed gate forces all outputs high;
- the open gate gives exactly one low output;
- the stored address loads from the address input whenever hold is low and stays frozen while it is high;
- the outputs stay steady across consecutive held cycles with steady gates.

Some behaviour can only be shown by the bench's scenarios:
- the exact weighting of address bits onto output positions;
- same-cycle tracking of the live address while transparent;
- which address is kept when hold rises;
- that reset clears the stored address to zero without touching the output gating.

The bench sweeps every gate combination against every address, both transparent and with each of the eight stored addresses held.

// File: rtl/ldec_pkg.sv
// Package: shared constants and helpers for the latched decoder.
// Assumes: callers size vectors from the parameters of the top module.
package ldec_pkg;

    // Gate state: open only when the high-true enable is 1 and the low-true enable is 0.
    function automatic logic gate_open(input logic en_hi, input logic en_lo_n);
        return en_hi & ~en_lo_n;
    endfunction

    // Number of select lines for a given address width.
    function automatic int unsigned lines_for(input int unsigned aw);
        return 1 << aw;
    endfunction

endpackage

// File: rtl/ldec_addr_hold.sv
// Module: ldec_addr_hold
// Holds the decoder address. The register loads the live address on every
// rising edge with hold low and freezes while hold is high. The effective
// address is the live input while hold is low, otherwise the register.
// Assumes: hold_i is synchronous to clk; reset is synchronous active-low.
module ldec_addr_hold #(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    output logic [ADDR_W-1:0] addr_eff_o
);

    logic [ADDR_W-1:0] addr_q;

    // Storage register: clear on reset, track address while transparent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!hold_i) begin
            addr_q <= addr_i;
        end
    end

    // Path select: live address while transparent, stored copy while held.
    always_comb begin
        addr_eff_o = hold_i ? addr_q : addr_i;
    end

    // R4: with hold low, the register takes the address at that edge.
    assert_load_when_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> (addr_q == $past(addr_i)));

    // R5: with hold high, the stored address does not move.
    assert_frozen_when_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(addr_q));

endmodule

// File: rtl/ldec_decode.sv
// Module: ldec_decode
// Binary to one-hot decoder, active-high. Output bit k is set when the
// address equals k. Purely combinational.
// Assumes: LINES equals 2**ADDR_W.
module ldec_decode #(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned LINES  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [LINES-1:0]  sel_o
);

    // One comparator per select line.
    for (genvar k = 0; k < LINES; k++) begin : g_line
        always_comb begin
            sel_o[k] = (addr_i == ADDR_W'(k));
        end
    end

    // R2: decoded vector has exactly one line set.
    always_comb begin
        assert_one_line_R2: assert ($onehot(sel_o) || $isunknown(addr_i));
    end

endmodule

// File: rtl/ldec_out_gate.sv
// Module: ldec_out_gate
// Applies the two-input output gate and inverts to active-low lines.
// With the gate closed every line is high.
// Assumes: the gate inputs may change at any time; the path is combinational.
module ldec_out_gate #(
    parameter int unsigned LINES = 8
) (
    input  logic             en_i,
    input  logic             en_n_i,
    input  logic [LINES-1:0] sel_i,
    output logic [LINES-1:0] y_n_o
);

    import ldec_pkg::*;

    logic open_w;

    // Gate condition from both enables.
    always_comb begin
        open_w = gate_open(en_i, en_n_i);
    end

    // Inversion with override: closed gate drives all lines high.
    always_comb begin
        y_n_o = open_w ? ~sel_i : '1;
    end

endmodule

// File: rtl/latched_decoder.sv
// Module: latched_decoder (top)
// Three-bit address register with a hold control, a one-of-eight decoder and
// a two-enable output gate producing active-low select lines.
// Assumes: all inputs synchronous to clk; rst_n synchronous, active-low,
// affecting only the stored address.
module latched_decoder #(
    parameter int unsigned ADDR_W = 3,
    localparam int unsigned LINES = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    input  logic              en_i,
    input  logic              en_n_i,
    output logic [LINES-1:0]  y_n_o
);

    logic [ADDR_W-1:0] addr_eff;
    logic [LINES-1:0]  sel;

    ldec_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .hold_i     (hold_i),
        .addr_eff_o (addr_eff)
    );

    ldec_decode #(.ADDR_W(ADDR_W), .LINES(LINES)) u_dec (
        .addr_i (addr_eff),
        .sel_o  (sel)
    );

    ldec_out_gate #(.LINES(LINES)) u_gate (
        .en_i   (en_i),
        .en_n_i (en_n_i),
        .sel_i  (sel),
        .y_n_o  (y_n_o)
    );

    // R6: closed gate means every output high.
    assert_closed_all_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && !en_n_i) |-> (y_n_o == '1));

    // R2: open gate means exactly one output low.
    assert_open_one_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !en_n_i) |-> ($countones(~y_n_o) == 1));

    // R5: held over two edges with steady gates, outputs do not move.
    assert_held_outputs_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && $past(hold_i) && $past(rst_n) && $stable(en_i) && $stable(en_n_i))
        |-> $stable(y_n_o));

endmodule

// File: tb/latched_decoder_tb.sv
module latched_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] addr;
    logic       hold;
    logic       en;
    logic       en_n;
    logic [7:0] y_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    latched_decoder u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_i (addr),
        .hold_i (hold),
        .en_i   (en),
        .en_n_i (en_n),
        .y_n_o  (y_n)
    );

    function automatic logic [7:0] model(input logic [2:0] a, input logic e, input logic en_low);
        if (e && !en_low) return ~(8'd1 << a);
        return 8'hFF;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Advance one full clock: through the rising edge to the next falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = 3'd3; hold = 1'b0; en = 1'b1; en_n = 1'b0;
        tick();
        // R7: reset does not force outputs; transparent path still decodes.
        #2 check("R7 reset no output force", y_n, model(3'd3, 1'b1, 1'b0));
        // R7: held during reset -> stored address cleared to zero.
        hold = 1'b1;
        tick();
        #2 check("R7 reset clears stored", y_n, model(3'd0, 1'b1, 1'b0));
        rst_n = 1'b1; hold = 1'b0;
        tick();

        // R1 R2 R3 R6: transparent sweep, all gates and addresses, same cycle.
        for (int g = 0; g < 4; g++) begin
            for (int a = 0; a < 8; a++) begin
                en = g[0]; en_n = g[1]; addr = 3'(a);
                #2 check("R1 R2 R3 R6 transparent", y_n, model(3'(a), g[0], g[1]));
                @(negedge clk);
            end
        end

        // R4 R5 R6 R8: capture each address, then sweep address and gates while held.
        for (int c = 0; c < 8; c++) begin
            hold = 1'b0; en = 1'b1; en_n = 1'b0; addr = 3'(c);
            tick();
            hold = 1'b1;
            addr = 3'(c + 3);
            #2 check("R4 captured address", y_n, model(3'(c), 1'b1, 1'b0));
            tick();
            for (int g = 0; g < 4; g++) begin
                for (int a = 0; a < 8; a++) begin
                    en = g[0]; en_n = g[1]; addr = 3'(a);
                    #2 check("R5 R6 held ignores address", y_n, model(3'(c), g[0], g[1]));
                    @(negedge clk);
                end
            end
            en = 1'b1; en_n = 1'b0; addr = 3'(7 - c);
            hold = 1'b0;
            #2 check("R8 release follows live", y_n, model(3'(7 - c), 1'b1, 1'b0));
            @(negedge clk);
        end

        // R7: reset mid-hold clears stored address to zero.
        hold = 1'b0; addr = 3'd6; tick();
        hold = 1'b1; tick();
        #2 check("R7 before reset", y_n, model(3'd6, 1'b1, 1'b0));
        rst_n = 1'b0; @(negedge clk); tick();
        rst_n = 1'b1;
        #2 check("R7 stored zero after reset", y_n, model(3'd0, 1'b1, 1'b0));
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule